// File: doc/BRIEF.md
# Programmable Pin Input Conditioner

This block holds one 32-bit configuration word per pin for a bank of general-purpose pins, and applies that word to each pin's signals. On the input side it takes the already-synchronized pad level and optionally removes short glitches with a counting filter. The filter samples on a per-pin divided tick. The block can then invert the level before the core sees it. On the output side it turns the core's output value and output enable into pad drive controls. It can emulate an open-drain driver. It also produces static pad controls for pull-up, pull-down, bus keeper and hysteresis. The actual analog pad is external.

Software reaches the words over a simple register bus. A write takes effect on the clock edge, and reads return data in the same cycle. Pins do not occupy slots in pin order. Pin `p` lives at slot `NUM_SLOTS-1-p`, so the lowest slots are unused placeholders. Two pins, chosen by parameter, are the I2C-capable pins, and they reset with their pull disabled.

Top module: `pincond_top`

## Requirements
- R1: After reset, ordinary pins read 0x00000090 (pull-up selected) and the two I2C-capable pins (default pins 2 and 3) read 0x00000080 (no pull).
- R2: Pin `p` is stored at slot `NUM_SLOTS-1-p` (default 8 slots, 6 pins). Slots below `NUM_SLOTS-NUM_PINS` read as zero, and writes to them change no pin.
- R3: A write stores the full 32-bit word. From the next cycle, a read of that slot returns the word.
- R4: Bits 4:3 select the pad pull control: 0 gives none, 1 gives pull-down, 2 gives pull-up and 3 gives keeper. At most one of the three outputs is high.
- R5: Bit 5 drives the pin's `hyst_en` output directly.
- R6: When bit 6 is set, `core_in` is the inverse of the filtered level.
- R7: When the filter field (bits 12:11) is 0, `core_in` follows `pad_in` in the same cycle, with no register delay.
- R8: When the filter field N is 1, 2 or 3, a new level reaches the filter output only after it has been sampled on N consecutive sample ticks. A shorter pulse leaves the output unchanged.
- R9: The divider field (bits 15:13) sets the tick period. A value of 0 gives a tick every clock, 1 to 6 give a tick every k clocks, and 7 acts as 6. After a write, the first tick falls on the k-th clock edge.
- R10: When bit 10 is clear, `pad_out=core_out` and `pad_oe=core_oe`. When bit 10 is set, `pad_out=0` and `pad_oe=core_oe & ~core_out`.
- R11: Any write to a pin's word clears that pin's pending filter count and its divider phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Slot index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | NUM_PINS | Synchronized pad input levels |
| core_out | input | NUM_PINS | Output value from the core |
| core_oe | input | NUM_PINS | Output enable from the core |
| core_in | output | NUM_PINS | Conditioned input levels to the core |
| pad_out | output | NUM_PINS | Pad output data |
| pad_oe | output | NUM_PINS | Pad output driver enable |
| pull_up | output | NUM_PINS | Pull-up resistor enable |
| pull_down | output | NUM_PINS | Pull-down resistor enable |
| keeper_en | output | NUM_PINS | Bus keeper enable |
| hyst_en | output | NUM_PINS | Input hysteresis enable |

## Verification
Random configuration words with the filter bypassed are combined with random pad and core levels. This separates the inversion, pull decode and open-drain paths, and it checks readback through the shuffled slot map. The filter is driven with steps held just long enough and one tick too short, for several sample counts and divider settings, including the clamped value 7. These cases tell a correct tick count from an off-by-one error. A step applied together with a rewrite of the same word shows whether the pending count really restarts. A placeholder write followed by a read of every pin slot exposes any address aliasing.

// File: rtl/pincond_pkg.sv
package pincond_pkg;

    localparam int WORD_W = 32;

    // Field positions inside a configuration word
    localparam int PULL_LSB  = 3;
    localparam int HYST_BIT  = 5;
    localparam int INV_BIT   = 6;
    localparam int OD_BIT    = 10;
    localparam int TAPS_LSB  = 11;
    localparam int DIV_LSB   = 13;

    localparam logic [WORD_W-1:0] RESET_PLAIN = 32'h0000_0090;
    localparam logic [WORD_W-1:0] RESET_I2C   = 32'h0000_0080;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_UP   = 2'd2,
        PULL_KEEP = 2'd3
    } pull_e;

    typedef struct packed {
        pull_e       pull;
        logic        hyst;
        logic        inv;
        logic        od;
        logic [1:0]  taps;
        logic [2:0]  div_code;
    } pin_cfg_t;

    function automatic pin_cfg_t decode_word(input logic [WORD_W-1:0] w);
        pin_cfg_t c;
        c.pull     = pull_e'(w[PULL_LSB +: 2]);
        c.hyst     = w[HYST_BIT];
        c.inv      = w[INV_BIT];
        c.od       = w[OD_BIT];
        c.taps     = w[TAPS_LSB +: 2];
        c.div_code = w[DIV_LSB +: 3];
        return c;
    endfunction

    // Last value of the divider counter before a tick (period minus one)
    function automatic logic [2:0] div_last(input logic [2:0] code);
        logic [2:0] period;
        period = (code == 3'd0) ? 3'd1 : ((code == 3'd7) ? 3'd6 : code);
        return period - 3'd1;
    endfunction

    function automatic int slot_of(input int pin, input int slots);
        return slots - 1 - pin;
    endfunction

    function automatic logic [WORD_W-1:0] reset_word(input int pin, input int i2c_a,
                                                     input int i2c_b);
        return ((pin == i2c_a) || (pin == i2c_b)) ? RESET_I2C : RESET_PLAIN;
    endfunction

endpackage

// File: rtl/pincond_cfg_regs.sv
module pincond_cfg_regs
    import pincond_pkg::*;
#(
    parameter int NUM_PINS  = 6,
    parameter int NUM_SLOTS = 8,
    parameter int ADDR_W    = 3,
    parameter int I2C_PIN_A = 2,
    parameter int I2C_PIN_B = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [WORD_W-1:0]                wdata,
    output logic [WORD_W-1:0]                rdata,
    output logic [NUM_PINS-1:0][WORD_W-1:0]  words,
    output logic [NUM_PINS-1:0]              restart
);

    logic [NUM_PINS-1:0] hit;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_word
        localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(slot_of(p, NUM_SLOTS));
        localparam logic [WORD_W-1:0] INIT = reset_word(p, I2C_PIN_A, I2C_PIN_B);

        assign hit[p]     = (addr == SLOT);
        assign restart[p] = we && hit[p];

        always_ff @(posedge clk) begin
            if (rst) begin
                words[p] <= INIT;
            end else if (restart[p]) begin
                words[p] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (hit[p]) begin
                rdata = words[p];
            end
        end
    end

endmodule

// File: rtl/pincond_filter.sv
module pincond_filter (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       raw,
    input  logic [1:0] taps,
    input  logic [2:0] last,
    output logic       filt
);

    logic [2:0] div_cnt;
    logic [1:0] run_cnt;
    logic       level;
    logic       tick;

    assign tick = (div_cnt >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            run_cnt <= '0;
            level   <= 1'b0;
        end else if (restart) begin
            div_cnt <= '0;
            run_cnt <= '0;
        end else begin
            div_cnt <= tick ? 3'd0 : div_cnt + 3'd1;
            if (taps == 2'd0) begin
                level   <= raw;
                run_cnt <= '0;
            end else if (tick) begin
                if (raw == level) begin
                    run_cnt <= '0;
                end else if (run_cnt == taps - 2'd1) begin
                    level   <= raw;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 2'd1;
                end
            end
        end
    end

    assign filt = (taps == 2'd0) ? raw : level;

endmodule

// File: rtl/pincond_pad.sv
module pincond_pad
    import pincond_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     core_out,
    input  logic     core_oe,
    output logic     pad_out,
    output logic     pad_oe,
    output logic     pull_up,
    output logic     pull_down,
    output logic     keeper_en,
    output logic     hyst_en
);

    always_comb begin
        if (cfg.od) begin
            pad_out = 1'b0;
            pad_oe  = core_oe && !core_out;
        end else begin
            pad_out = core_out;
            pad_oe  = core_oe;
        end
        pull_up   = (cfg.pull == PULL_UP);
        pull_down = (cfg.pull == PULL_DOWN);
        keeper_en = (cfg.pull == PULL_KEEP);
        hyst_en   = cfg.hyst;
    end

endmodule

// File: rtl/pincond_top.sv
module pincond_top
    import pincond_pkg::*;
#(
    parameter int NUM_PINS  = 6,
    parameter int NUM_SLOTS = 8,
    parameter int I2C_PIN_A = 2,
    parameter int I2C_PIN_B = 3,
    localparam int ADDR_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_PINS-1:0]  pad_in,
    input  logic [NUM_PINS-1:0]  core_out,
    input  logic [NUM_PINS-1:0]  core_oe,
    output logic [NUM_PINS-1:0]  core_in,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  pad_oe,
    output logic [NUM_PINS-1:0]  pull_up,
    output logic [NUM_PINS-1:0]  pull_down,
    output logic [NUM_PINS-1:0]  keeper_en,
    output logic [NUM_PINS-1:0]  hyst_en
);

    logic [NUM_PINS-1:0][WORD_W-1:0] words;
    logic [NUM_PINS-1:0]             restart;

    pincond_cfg_regs #(
        .NUM_PINS  (NUM_PINS),
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .I2C_PIN_A (I2C_PIN_A),
        .I2C_PIN_B (I2C_PIN_B)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .words   (words),
        .restart (restart)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_cfg_t cfg;
        logic     filt;

        assign cfg = decode_word(words[p]);

        pincond_filter u_filter (
            .clk     (clk),
            .rst     (rst),
            .restart (restart[p]),
            .raw     (pad_in[p]),
            .taps    (cfg.taps),
            .last    (div_last(cfg.div_code)),
            .filt    (filt)
        );

        assign core_in[p] = filt ^ cfg.inv;

        pincond_pad u_pad (
            .cfg       (cfg),
            .core_out  (core_out[p]),
            .core_oe   (core_oe[p]),
            .pad_out   (pad_out[p]),
            .pad_oe    (pad_oe[p]),
            .pull_up   (pull_up[p]),
            .pull_down (pull_down[p]),
            .keeper_en (keeper_en[p]),
            .hyst_en   (hyst_en[p])
        );
    end

endmodule

// File: rtl/pincond_checker.sv
module pincond_checker
    import pincond_pkg::*;
#(
    parameter int NUM_PINS  = 6,
    parameter int NUM_SLOTS = 8,
    parameter int I2C_PIN_A = 2,
    parameter int I2C_PIN_B = 3,
    localparam int ADDR_W   = $clog2(NUM_SLOTS)
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_wdata,
    input logic [31:0]         reg_rdata,
    input logic [NUM_PINS-1:0] core_out,
    input logic [NUM_PINS-1:0] core_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pull_up,
    input logic [NUM_PINS-1:0] pull_down,
    input logic [NUM_PINS-1:0] keeper_en
);

    function automatic logic used_slot(input logic [ADDR_W-1:0] a);
        return (int'(a) >= NUM_SLOTS - NUM_PINS) && (int'(a) < NUM_SLOTS);
    endfunction

    function automatic logic [31:0] slot_reset(input logic [ADDR_W-1:0] a);
        return used_slot(a) ? reset_word(NUM_SLOTS - 1 - int'(a), I2C_PIN_A, I2C_PIN_B)
                            : 32'h0;
    endfunction

    // R1: first cycle out of reset reads the reset word of the addressed slot
    assert_reset_word_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> reg_rdata == slot_reset(reg_addr));

    // R2: placeholder slots always read zero
    assert_placeholder_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !used_slot(reg_addr) |-> reg_rdata == 32'h0);

    // R3: a write to a used slot reads back on the next cycle
    assert_readback_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_we && used_slot(reg_addr)) ##1 (reg_addr == $past(reg_addr))
            |-> reg_rdata == $past(reg_wdata));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        // R4: at most one pull control active
        assert_pull_onehot_R4: assert property (@(posedge clk) disable iff (rst)
            $onehot0({pull_up[p], pull_down[p], keeper_en[p]}));

        // R10: a driven low is driven in both output modes
        assert_low_driven_R10: assert property (@(posedge clk) disable iff (rst)
            (core_oe[p] && !core_out[p]) |-> (pad_oe[p] && !pad_out[p]));

        // R10: no core enable means no pad drive
        assert_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
            !core_oe[p] |-> !pad_oe[p]);
    end

endmodule

bind pincond_top pincond_checker #(
    .NUM_PINS  (NUM_PINS),
    .NUM_SLOTS (NUM_SLOTS),
    .I2C_PIN_A (I2C_PIN_A),
    .I2C_PIN_B (I2C_PIN_B)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pull_up   (pull_up),
    .pull_down (pull_down),
    .keeper_en (keeper_en)
);

// File: tb/pincond_top_bench.sv
module pincond_top_bench;

    localparam int NP = 6;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] core_out = '0;
    logic [NP-1:0] core_oe = '0;
    logic [NP-1:0] core_in, pad_out, pad_oe, pull_up, pull_down, keeper_en, hyst_en;

    int checks = 0;
    int fails  = 0;
    logic [31:0] shadow [NP];

    always #10 clk = ~clk;

    pincond_top u_pincond_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up),
        .pull_down(pull_down), .keeper_en(keeper_en), .hyst_en(hyst_en)
    );

    function automatic logic [2:0] slot(input int p);
        return 3'(NS - 1 - p);
    endfunction

    function automatic logic [31:0] exp_reset(input int p);
        return (p == 2 || p == 3) ? 32'h80 : 32'h90;
    endfunction

    function automatic logic [31:0] mk(input int taps, input int dv, input int inv);
        return (32'(dv) << 13) | (32'(taps) << 11) | (32'(inv) << 6);
    endfunction

    function automatic logic [3:0] exp_pulls(input logic [31:0] w);
        // {up, down, keep, hyst}
        return {w[4:3] == 2'd2, w[4:3] == 2'd1, w[4:3] == 2'd3, w[5]};
    endfunction

    function automatic logic [1:0] exp_drive(input logic [31:0] w, input logic o, input logic e);
        // {pad_out, pad_oe}
        return w[10] ? {1'b0, e & ~o} : {o, e};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int p, input logic [31:0] w);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = slot(p); reg_wdata = w;
        @(negedge clk);
        reg_we = 1'b0;
        shadow[p] = w;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        step(3);
        rst = 1'b0;

        // R1 and R2: reset words through the slot map, placeholders read zero
        for (int p = 0; p < NP; p++) begin
            shadow[p] = exp_reset(p);
            reg_addr = slot(p); #1;
            check($sformatf("R1 pin%0d reset", p), reg_rdata, exp_reset(p));
        end
        reg_addr = 3'd0; #1; check("R2 slot0 zero", reg_rdata, 0);
        reg_addr = 3'd1; #1; check("R2 slot1 zero", reg_rdata, 0);
        check("R1 pin2 no pull", {31'd0, pull_up[2]}, 0);
        check("R1 pin0 pull-up", {31'd0, pull_up[0]}, 1);

        // Random bypass configurations: R3 R4 R5 R6 R7 R10
        for (int i = 0; i < 40; i++) begin
            int p;
            logic [31:0] w;
            p = int'($urandom % NP);
            w = $urandom & ~(32'h3 << 11);
            write_cfg(p, w);
            pad_in = NP'($urandom); core_out = NP'($urandom); core_oe = NP'($urandom);
            #1;
            check("R3 readback", reg_rdata, w);
            check("R6 R7 bypass core_in", {31'd0, core_in[p]}, {31'd0, pad_in[p] ^ w[6]});
            check("R4 R5 pad controls", {28'd0, pull_up[p], pull_down[p], keeper_en[p], hyst_en[p]},
                  {28'd0, exp_pulls(w)});
            check("R10 drive", {30'd0, pad_out[p], pad_oe[p]},
                  {30'd0, exp_drive(w, core_out[p], core_oe[p])});
        end

        // R2: placeholder write leaves every pin word intact
        @(negedge clk); reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); reg_we = 1'b0;
        #1; check("R2 placeholder reads zero", reg_rdata, 0);
        for (int p = 0; p < NP; p++) begin
            reg_addr = slot(p); #1;
            check($sformatf("R2 pin%0d unchanged", p), reg_rdata, shadow[p]);
        end

        // R10 directed: open-drain high releases pad
        write_cfg(1, 32'h400); core_out[1] = 1'b1; core_oe[1] = 1'b1; #1;
        check("R10 od high released", {30'd0, pad_out[1], pad_oe[1]}, 0);

        // R7 with R6: same-cycle bypass with inversion on pin 0
        core_oe = '0;
        write_cfg(0, mk(0, 0, 1));
        pad_in[0] = 1'b1; #1; check("R7 R6 same cycle invert", {31'd0, core_in[0]}, 0);
        pad_in[0] = 1'b0; #1; check("R7 R6 same cycle invert", {31'd0, core_in[0]}, 1);
        write_cfg(0, mk(0, 0, 0)); step(2);
        check("R7 settled low", {31'd0, core_in[0]}, 0);

        // R8: N=3 every clock
        write_cfg(0, mk(3, 0, 0));
        pad_in[0] = 1'b1;
        step(2); check("R8 N3 before third tick", {31'd0, core_in[0]}, 0);
        step(1); check("R8 N3 after third tick", {31'd0, core_in[0]}, 1);
        pad_in[0] = 1'b0; step(2); pad_in[0] = 1'b1;
        step(1); check("R8 two-tick pulse rejected", {31'd0, core_in[0]}, 1);
        step(5); check("R8 pulse stays rejected", {31'd0, core_in[0]}, 1);

        // R8: N=1
        write_cfg(0, mk(1, 0, 0));
        pad_in[0] = 1'b0;
        step(1); check("R8 N1 one tick", {31'd0, core_in[0]}, 0);

        // R9: divider 3, N=1
        write_cfg(0, mk(1, 3, 0));
        pad_in[0] = 1'b1;
        step(2); check("R9 div3 before tick", {31'd0, core_in[0]}, 0);
        step(1); check("R9 div3 at tick", {31'd0, core_in[0]}, 1);

        // R9: divider 7 acts as 6
        write_cfg(0, mk(1, 7, 0));
        pad_in[0] = 1'b0;
        step(5); check("R9 div7 before sixth edge", {31'd0, core_in[0]}, 1);
        step(1); check("R9 div7 as six", {31'd0, core_in[0]}, 0);

        // R8 with R9: N=3, divider 2
        write_cfg(0, mk(3, 2, 0));
        pad_in[0] = 1'b1;
        step(5); check("R8 R9 N3 div2 early", {31'd0, core_in[0]}, 0);
        step(1); check("R8 R9 N3 div2 accepted", {31'd0, core_in[0]}, 1);

        // R11: rewrite at the moment the input steps restarts the count
        write_cfg(0, mk(2, 0, 0));
        @(negedge clk);
        pad_in[0] = 1'b0; reg_we = 1'b1; reg_addr = slot(0); reg_wdata = mk(2, 0, 0);
        @(negedge clk); reg_we = 1'b0;
        step(1); check("R11 count restarted", {31'd0, core_in[0]}, 1);
        step(1); check("R11 accepted after restart", {31'd0, core_in[0]}, 0);

        finish_run();
    end

endmodule